// File: doc/BRIEF.md
# Heartbeat and Fault Tone Supervisor

This block manages the slow status tones exchanged between neighbouring units on a daisy-chained link. On the transmit side it sends a short heartbeat burst at a fixed period while the local unit is healthy. While the local fault flag is set, it sends a longer fault burst that repeats at a faster rate. On the receive side it counts pulse edges on the incoming line and groups them into bursts. A burst of moderate length is taken as a heartbeat. A long burst is taken as a fault tone.

Two checks run on the received heartbeats. A watchdog raises a sticky flag when no valid tone arrives within a timeout window. A lower limit raises a second sticky flag when a heartbeat follows the previous tone too soon. A detected fault tone pulls an active-low fault output low within a couple of clock cycles. That output stays low while fault tones keep arriving and is released after a hold window with no fault tone.

All timing parameters are in clock cycles. In a chip the clock would be the slow tone clock, and the parameters would be scaled to the real periods: roughly 400 ms between heartbeats, 50 ms between fault tones, a 1 s timeout and a 200 ms fast limit. The defaults are shrunk so that the block can be exercised quickly. There is no streamed data, so every pin is a plain control or status signal.

Top module: `hbft_sup`

## Requirements
- R1: While reset is held, `tx_o` is 0, `nfault_o` is 1, and `hb_miss_o` and `hb_fast_o` are 0.
- R2: With `fault_i` low, the block sends a heartbeat burst of HB_PULSES pulses. Each pulse is high for PULSE_HI cycles within a PULSE_PERIOD-cycle slot. The first burst starts HB_PERIOD cycles after reset, and later bursts start every HB_PERIOD cycles, measured start to start.
- R3: When `fault_i` rises while no burst is in flight, a fault burst of FT_PULSES pulses starts on the next clock edge. While `fault_i` stays high, fault bursts start every FT_PERIOD cycles and no heartbeat is sent.
- R4: After `fault_i` falls, once any burst in flight has ended, the next heartbeat starts HB_PERIOD cycles later.
- R5: Received rising edges that are less than 2*PULSE_PERIOD cycles apart belong to one burst. A burst with at least HB_DET and fewer than FT_DET edges is a heartbeat. A burst with fewer than HB_DET edges is ignored: it does not restart the timeout and does not set `hb_fast_o`.
- R6: `hb_miss_o` is set once HB_TIMEOUT cycles pass without a heartbeat or fault-tone detection. The window starts at reset and restarts at each detection. The flag is never set earlier.
- R7: A heartbeat detected fewer than HB_FAST cycles after the previous detection sets `hb_fast_o`. The first heartbeat after reset never does.
- R8: Both flags hold until `clr_i` is high for a cycle; a set in the same cycle wins over the clear. An expired window that has been cleared raises `hb_miss_o` again only after a new detection and a new expiry.
- R9: `nfault_o` goes low within 3 cycles of the FT_DET-th rising edge of a received burst, and not before that edge.
- R10: `nfault_o` returns high FT_HOLD cycles after the last fault-tone detection.
- R11: A fault-tone detection never sets `hb_fast_o`, however soon it follows a heartbeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tone clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 1 | Local fault present |
| clr_i | input | 1 | Clears the sticky heartbeat flags |
| rx_i | input | 1 | Incoming pulse line, synchronous to clk_i |
| tx_o | output | 1 | Outgoing pulse line |
| nfault_o | output | 1 | Fault-tone seen, active low |
| hb_miss_o | output | 1 | Sticky missing-heartbeat flag |
| hb_fast_o | output | 1 | Sticky heartbeat-too-fast flag |

## Verification
The bound assertions check, on every cycle, the following properties:
- a detected fault tone drives `nfault_o` low on the next cycle;
- the output is released only when no detection occurs in the same cycle;
- both flags stay set until cleared;
- each flag rises only with its own cause: a heartbeat detection for the fast flag, and no detection for the missing flag;
- a received burst is never classed as both kinds;
- the transmitted line stays low for at least two cycles between pulses.

Period and burst lengths, the resume delay after a fault, the detection thresholds at 19 and 20 edges, and the fast limit under random heartbeat spacing can only be shown by the bench's timed scenarios. The same holds for the fault-tone restart of the timeout and the hold-time release of `nfault_o`.

// File: rtl/hbft_pkg.sv
`timescale 1ns/1ps
package hbft_pkg;
  typedef enum logic {
    BURST_HB = 1'b0,
    BURST_FT = 1'b1
  } burst_kind_e;
endpackage

// File: rtl/hbft_tone_tx.sv
`timescale 1ns/1ps
module hbft_tone_tx #(
  parameter int PULSE_HI     = 2,
  parameter int PULSE_PERIOD = 6,
  parameter int HB_PULSES    = 30,
  parameter int FT_PULSES    = 90,
  parameter int HB_PERIOD    = 2000,
  parameter int FT_PERIOD    = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  output logic tx_o
);
  import hbft_pkg::*;

  localparam int WAIT_MAX = (HB_PERIOD > FT_PERIOD) ? HB_PERIOD : FT_PERIOD;
  localparam int WW       = $clog2(WAIT_MAX + 1);
  localparam int NMAX     = (HB_PULSES > FT_PULSES) ? HB_PULSES : FT_PULSES;
  localparam int NW       = $clog2(NMAX + 1);
  localparam int PW       = $clog2(PULSE_PERIOD + 1);

  logic          busy_q;
  burst_kind_e   kind_q;
  logic          fmode_q;
  logic [WW-1:0] wait_q;
  logic [NW-1:0] pcnt_q;
  logic [PW-1:0] phase_q;

  logic start_ft, start_hb, leave_ft, last_pulse, slot_end;

  // fault burst: at once when a fault appears, then at the fault period
  assign start_ft = fault_i && !busy_q && (!fmode_q || wait_q >= WW'(FT_PERIOD - 1));
  assign start_hb = !fault_i && !fmode_q && !busy_q && wait_q >= WW'(HB_PERIOD - 1);
  // leaving fault mode restarts the heartbeat period
  assign leave_ft = fmode_q && !fault_i && !busy_q;
  assign slot_end = (phase_q == PW'(PULSE_PERIOD - 1));
  assign last_pulse = (kind_q == BURST_FT) ? (pcnt_q == NW'(FT_PULSES - 1))
                                           : (pcnt_q == NW'(HB_PULSES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      kind_q  <= BURST_HB;
      fmode_q <= 1'b0;
      wait_q  <= '0;
      pcnt_q  <= '0;
      phase_q <= '0;
    end else begin
      if (start_ft || start_hb) begin
        busy_q  <= 1'b1;
        kind_q  <= start_ft ? BURST_FT : BURST_HB;
        pcnt_q  <= '0;
        phase_q <= '0;
        wait_q  <= '0;
        if (start_ft) fmode_q <= 1'b1;
      end else begin
        if (leave_ft) begin
          fmode_q <= 1'b0;
          wait_q  <= '0;
        end else if (wait_q != WW'(WAIT_MAX)) begin
          wait_q <= wait_q + 1'b1;
        end
        if (busy_q) begin
          if (slot_end) begin
            phase_q <= '0;
            if (last_pulse) busy_q <= 1'b0;
            else            pcnt_q <= pcnt_q + 1'b1;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
      end
    end
  end

  assign tx_o = busy_q && (phase_q < PW'(PULSE_HI));
endmodule

// File: rtl/hbft_tone_rx.sv
`timescale 1ns/1ps
module hbft_tone_rx #(
  parameter int GAP_LIMIT = 12,
  parameter int HB_DET    = 20,
  parameter int FT_DET    = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic hb_evt_o,
  output logic ft_evt_o
);
  localparam int CW = $clog2(FT_DET + 1);
  localparam int GW = $clog2(GAP_LIMIT + 1);

  logic          rx_q, in_burst_q;
  logic [CW-1:0] ecnt_q;
  logic [GW-1:0] gap_q;
  logic          rise;

  assign rise = rx_i && !rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q       <= 1'b0;
      in_burst_q <= 1'b0;
      ecnt_q     <= '0;
      gap_q      <= '0;
      hb_evt_o   <= 1'b0;
      ft_evt_o   <= 1'b0;
    end else begin
      rx_q     <= rx_i;
      hb_evt_o <= 1'b0;
      ft_evt_o <= 1'b0;
      if (rise) begin
        gap_q      <= '0;
        in_burst_q <= 1'b1;
        if (!in_burst_q) begin
          ecnt_q <= CW'(1);
        end else if (ecnt_q != CW'(FT_DET)) begin
          ecnt_q <= ecnt_q + 1'b1;
          // fault tone is flagged the moment its threshold edge arrives
          if (ecnt_q == CW'(FT_DET - 1)) ft_evt_o <= 1'b1;
        end
      end else if (in_burst_q) begin
        if (gap_q == GW'(GAP_LIMIT - 1)) begin
          in_burst_q <= 1'b0;
          hb_evt_o   <= (ecnt_q >= CW'(HB_DET)) && (ecnt_q < CW'(FT_DET));
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hbft_watch.sv
`timescale 1ns/1ps
module hbft_watch #(
  parameter int HB_TIMEOUT = 5000,
  parameter int HB_FAST    = 1000,
  parameter int FT_HOLD    = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hb_evt_i,
  input  logic ft_evt_i,
  output logic miss_o,
  output logic fast_o,
  output logic nfault_o
);
  localparam int IW = $clog2(HB_TIMEOUT + 1);
  localparam int HW = $clog2(FT_HOLD + 1);

  logic [IW-1:0] ivl_q;
  logic [HW-1:0] hold_q;
  logic          seen_q, flt_q, any_evt;

  assign any_evt = hb_evt_i || ft_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q  <= '0;
      seen_q <= 1'b0;
      miss_o <= 1'b0;
      fast_o <= 1'b0;
      flt_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (any_evt) begin
        ivl_q  <= '0;
        seen_q <= 1'b1;
      end else if (ivl_q != IW'(HB_TIMEOUT)) begin
        ivl_q <= ivl_q + 1'b1;
      end

      // raised only on the expiring step; saturation keeps it from re-arming
      if (!any_evt && ivl_q == IW'(HB_TIMEOUT - 1)) miss_o <= 1'b1;
      else if (clr_i)                                 miss_o <= 1'b0;

      if (hb_evt_i && seen_q && ivl_q < IW'(HB_FAST)) fast_o <= 1'b1;
      else if (clr_i)                                   fast_o <= 1'b0;

      if (ft_evt_i) begin
        flt_q  <= 1'b1;
        hold_q <= '0;
      end else if (flt_q) begin
        if (hold_q == HW'(FT_HOLD - 1)) flt_q <= 1'b0;
        else                            hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign nfault_o = !flt_q;
endmodule

// File: rtl/hbft_sup.sv
`timescale 1ns/1ps
module hbft_sup #(
  parameter int PULSE_HI     = 2,
  parameter int PULSE_PERIOD = 6,
  parameter int HB_PULSES    = 30,
  parameter int HB_DET       = 20,
  parameter int FT_PULSES    = 90,
  parameter int FT_DET       = 60,
  parameter int HB_PERIOD    = 2000,
  parameter int FT_PERIOD    = 1000,
  parameter int HB_TIMEOUT   = 5000,
  parameter int HB_FAST      = 1000,
  parameter int FT_HOLD      = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic clr_i,
  input  logic rx_i,
  output logic tx_o,
  output logic nfault_o,
  output logic hb_miss_o,
  output logic hb_fast_o
);
  localparam int GAP_LIMIT = 2 * PULSE_PERIOD;

  logic hb_evt, ft_evt;

  hbft_tone_tx #(
    .PULSE_HI(PULSE_HI), .PULSE_PERIOD(PULSE_PERIOD),
    .HB_PULSES(HB_PULSES), .FT_PULSES(FT_PULSES),
    .HB_PERIOD(HB_PERIOD), .FT_PERIOD(FT_PERIOD)
  ) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .tx_o(tx_o)
  );

  hbft_tone_rx #(
    .GAP_LIMIT(GAP_LIMIT), .HB_DET(HB_DET), .FT_DET(FT_DET)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
    .hb_evt_o(hb_evt), .ft_evt_o(ft_evt)
  );

  hbft_watch #(
    .HB_TIMEOUT(HB_TIMEOUT), .HB_FAST(HB_FAST), .FT_HOLD(FT_HOLD)
  ) u_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .hb_evt_i(hb_evt), .ft_evt_i(ft_evt),
    .miss_o(hb_miss_o), .fast_o(hb_fast_o), .nfault_o(nfault_o)
  );
endmodule

// File: rtl/hbft_chk.sv
`timescale 1ns/1ps
module hbft_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic tx_o,
  input logic nfault_o,
  input logic hb_miss_o,
  input logic hb_fast_o,
  input logic hb_evt,
  input logic ft_evt
);
  // R9: detection pulls the fault output low next cycle
  a_r9_tone_drives_nfault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ft_evt |=> !nfault_o);
  // R10: release only while no detection happens
  a_r10_release_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nfault_o) |-> !$past(ft_evt));
  // R8: sticky flags
  a_r8_fast_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_fast_o && !clr_i) |=> hb_fast_o);
  a_r8_miss_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_miss_o && !clr_i) |=> hb_miss_o);
  // R7 and R11: fast flag needs a heartbeat detection
  a_r7_fast_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hb_fast_o) |-> $past(hb_evt));
  // R6: timeout only when nothing was detected
  a_r6_miss_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hb_miss_o) |-> (!$past(hb_evt) && !$past(ft_evt)));
  // R5: one classification per burst
  a_r5_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hb_evt && ft_evt));
  // R2: low part of a pulse slot lasts at least two cycles
  a_r2_low_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_o) |=> !tx_o);
endmodule

bind hbft_sup hbft_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .tx_o(tx_o),
  .nfault_o(nfault_o), .hb_miss_o(hb_miss_o), .hb_fast_o(hb_fast_o),
  .hb_evt(hb_evt), .ft_evt(ft_evt)
);

// File: tb/sim_hbft_sup.sv
`timescale 1ns/1ps
module sim_hbft_sup;
  localparam int PH = 2, PP = 6, HBN = 30, HBD = 20, FTN = 90, FTD = 60;

  logic clk = 1'b0, rst_ni = 1'b0, fault_i = 1'b0, clr_i = 1'b0, rx_i = 1'b0;
  logic tx_o, nfault_o, hb_miss_o, hb_fast_o;

  int total = 0, bad = 0, cyc = 0, t0 = 0, nb = 0, wbad = 0, hi_len = 0;
  int last_rise = 0, last_ft = 0;
  int st[64], cn[64];
  bit tx_q = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  hbft_sup u0 (.clk_i(clk), .rst_ni(rst_ni), .fault_i(fault_i), .clr_i(clr_i),
    .rx_i(rx_i), .tx_o(tx_o), .nfault_o(nfault_o), .hb_miss_o(hb_miss_o),
    .hb_fast_o(hb_fast_o));

  // transmit-line monitor: burst starts, pulse counts, pulse high widths
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tx_o && !tx_q) begin
      if (nb == 0 || cyc - last_rise > 20) begin
        if (nb < 64) begin st[nb] = cyc; cn[nb] = 1; nb = nb + 1; end
      end else if (nb <= 64) cn[nb-1] = cn[nb-1] + 1;
      last_rise = cyc;
    end
    if (tx_o) hi_len = hi_len + 1;
    else begin
      if (tx_q && hi_len != PH) wbad = wbad + 1;
      hi_len = 0;
    end
    tx_q = tx_o;
  end

  function automatic bit fast_expected(input int gap);
    return gap < 1000;
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0; @(negedge clk);
  endtask

  task automatic send_burst(input int n, input bit ftc);
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < PP; j++) begin
        if (ftc && i == FTD-1 && j == 0) chk_eq("R9 fault output high before threshold edge", nfault_o, 1);
        rx_i = (j < PH);
        @(negedge clk);
        if (i == FTD-1 && j == 0) last_ft = cyc;
        if (ftc && i == FTD-1 && j == 2) chk_eq("R9 fault output low after threshold edge", nfault_o, 0);
      end
    end
    rx_i = 1'b0;
  endtask

  task automatic tx_thread();
    int f, c;
    while (nb < 2) @(negedge clk);
    wait_until(st[1] + 300);
    chk_eq("R2 first heartbeat pulse count", cn[0], HBN);
    chk_eq("R2 second heartbeat pulse count", cn[1], HBN);
    chk_rng("R2 first heartbeat start after reset", st[0] - t0, 1998, 2003);
    chk_eq("R2 heartbeat period", st[1] - st[0], 2000);
    wait_until(st[1] + 500);
    fault_i = 1'b1; f = cyc;
    while (nb < 5) @(negedge clk);
    wait_until(st[4] + 700);
    chk_rng("R3 fault burst starts at once", st[2] - f, 0, 3);
    chk_eq("R3 fault burst count a", cn[2], FTN);
    chk_eq("R3 fault burst count b", cn[3], FTN);
    chk_eq("R3 fault burst count c", cn[4], FTN);
    chk_eq("R3 fault period a", st[3] - st[2], 1000);
    chk_eq("R3 fault period b", st[4] - st[3], 1000);
    fault_i = 1'b0; c = cyc;
    while (nb < 7) @(negedge clk);
    wait_until(st[6] + 300);
    chk_eq("R4 heartbeat count after fault", cn[5], HBN);
    chk_rng("R4 heartbeat resumes one period after clear", st[5] - c, 1999, 2004);
    chk_eq("R2 period after resume", st[6] - st[5], 2000);
    chk_eq("R2 pulse high width errors", wbad, 0);
  endtask

  task automatic rx_thread();
    int prev, p19, gap, h, r;
    bit e;
    wait_until(t0 + 4900);
    chk_eq("R6 no miss before timeout", hb_miss_o, 0);
    wait_until(t0 + 5100);
    chk_eq("R6 miss after timeout from reset", hb_miss_o, 1);
    wait_until(t0 + 5300);
    chk_eq("R8 miss sticky", hb_miss_o, 1);
    pulse_clr();
    chk_eq("R8 miss cleared", hb_miss_o, 0);
    wait_until(t0 + 5900);
    chk_eq("R8 no re-raise without new expiry", hb_miss_o, 0);
    prev = cyc; send_burst(HBN, 0); repeat (30) @(negedge clk);
    chk_eq("R7 first heartbeat not fast", hb_fast_o, 0);
    chk_eq("R5 heartbeat keeps miss clear", hb_miss_o, 0);
    for (int k = 0; k < 8; k++) begin
      gap = ($urandom % 2 == 1) ? 300 + int'($urandom % 600) : 1100 + int'($urandom % 1400);
      e = fast_expected(gap);
      wait_until(prev + gap); prev = cyc;
      send_burst(HBN, 0); repeat (30) @(negedge clk);
      chk_eq("R7 fast flag vs random spacing", hb_fast_o, e);
      chk_eq("R6 no miss with regular heartbeats", hb_miss_o, 0);
      pulse_clr();
    end
    wait_until(prev + 400); prev = cyc;
    send_burst(HBD, 0); repeat (30) @(negedge clk);
    chk_eq("R5 burst of exactly HB_DET detected", hb_fast_o, 1);
    pulse_clr();
    wait_until(prev + 1500); p19 = cyc;
    send_burst(HBD - 1, 0); repeat (30) @(negedge clk);
    chk_eq("R5 short burst sets no fast", hb_fast_o, 0);
    wait_until(p19 + 400); prev = cyc;
    send_burst(HBN, 0); repeat (30) @(negedge clk);
    chk_eq("R5 short burst not used as reference", hb_fast_o, 0);
    wait_until(prev + 3000);
    send_burst(15, 0); repeat (30) @(negedge clk);
    chk_eq("R5 ignored burst sets no fast", hb_fast_o, 0);
    wait_until(prev + 5050);
    chk_eq("R6 no miss before expiry", hb_miss_o, 0);
    wait_until(prev + 5350);
    chk_eq("R5 ignored burst did not restart timeout", hb_miss_o, 1);
    pulse_clr();
    h = cyc; send_burst(HBN, 0);
    wait_until(h + 300); send_burst(FTN, 1); repeat (30) @(negedge clk);
    chk_eq("R11 fault tone sets no fast", hb_fast_o, 0);
    wait_until(h + 1300); send_burst(FTN, 0);
    chk_eq("R10 output held low between tones", nfault_o, 0);
    wait_until(h + 2300); send_burst(FTN, 0); r = last_ft;
    wait_until(r + 1800);
    chk_eq("R10 still low inside hold", nfault_o, 0);
    wait_until(r + 2200);
    chk_eq("R10 released after hold", nfault_o, 1);
    wait_until(r + 4900);
    chk_eq("R6 fault tone restarted timeout", hb_miss_o, 0);
    wait_until(r + 5150);
    chk_eq("R6 miss after fault-tone window", hb_miss_o, 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (5) @(negedge clk);
    chk_eq("R1 tx idle in reset", tx_o, 0);
    chk_eq("R1 fault output high in reset", nfault_o, 1);
    chk_eq("R1 miss clear in reset", hb_miss_o, 0);
    chk_eq("R1 fast clear in reset", hb_fast_o, 0);
    rst_ni = 1'b1; t0 = cyc;
    fork
      tx_thread();
      rx_thread();
    join
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule